// File: doc/BRIEF.md
# Panel Frame Timing Tracker

This block follows the incoming sync timing of a flat-panel timing controller. It watches a horizontal sync and a vertical sync input, both active low and synchronous to the pixel clock. From them it derives two position counters: a line counter that starts at the first visible line of each frame, and a pixel counter that starts at the first visible pixel of each line. The point where each counter starts is set by two programmable backporch values. Strobe generators further downstream read the counters to place their own edges within the frame.

The block also produces a data-enable strobe that is high during the visible area. It holds the panel outputs off after reset until a selectable number of frames has passed, and it drives the pixel data output. When a mode bit is set, that output is forced to white during vertical blanking.

A sync falling edge is taken at the clock edge where the sync input is first sampled low after being sampled high. All registered outputs change at that same edge.

Top module: `panel_frame_tracker`

## Requirements
- R1: While `rst_n` is low and right after it is released, `line_vis`, `pix_vis`, `data_en`, `out_en`, `line_cnt`, `pix_cnt` and `pix_out` are all zero.
- R2: A VSYNC falling edge clears `line_vis` and `line_cnt` at that edge and restarts the count of HSYNC falling edges.
- R3: With `vbp` = N (N ≥ 1), the N-th HSYNC falling edge after a VSYNC falling edge sets `line_vis` and loads `line_cnt` with 0. Each later HSYNC falling edge in the frame adds 1 to `line_cnt`.
- R4: An HSYNC falling edge clears `pix_vis` and `pix_cnt`. With `hbp` = H (H ≥ 1), `pix_vis` is high H clock edges after that falling edge with `pix_cnt` = 0, and from then on `pix_cnt` increments by 1 on every clock edge.
- R5: `data_en` is high exactly when `line_vis` and `pix_vis` are both high.
- R6: With `test_mode` low, `out_en` rises at the VSYNC falling edge whose ordinal since reset is `pwr_dly`+2. Codes 0, 1, 2 and 3 give the 2nd, 3rd, 4th and 5th VSYNC.
- R7: With `test_mode` high, `out_en` rises at the first clock edge after reset, whatever `pwr_dly` holds.
- R8: Once `out_en` is high it stays high until reset, and later frames do not change it. The VSYNC count saturates rather than wrapping.
- R9: `pix_out` is all zeros while `out_en` is low. With `out_en` high, `pix_out` takes one of three values: all ones when `white_en` is 1 and `line_vis` is 0; otherwise `pix_in` while `data_en` is high; otherwise all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync, active low |
| vsync | input | 1 | Vertical sync, active low |
| vbp | input | CNT_W | HSYNC falling edges from VSYNC fall to the first visible line |
| hbp | input | CNT_W | Clocks from HSYNC fall to the first visible pixel |
| pwr_dly | input | 2 | Power-up delay code (VSYNC ordinal minus 2) |
| test_mode | input | 1 | Bypasses the power-up delay |
| white_en | input | 1 | Forces white data during vertical blanking |
| pix_in | input | DATA_W | Incoming pixel data |
| line_cnt | output | CNT_W | Current visible line number |
| pix_cnt | output | CNT_W | Current visible pixel number |
| line_vis | output | 1 | Inside the visible lines |
| pix_vis | output | 1 | Inside the visible pixels of a line |
| data_en | output | 1 | Visible-area data strobe |
| out_en | output | 1 | Panel outputs enabled |
| pix_out | output | DATA_W | Pixel data to the panel |

## Verification
The bench sweeps small horizontal backporch values (1, 2 and 5), vertical backporch values (1 and 3), all four delay codes, and both settings of the test input. Every clock of every line is compared against arithmetic expectations. Varying the backporch values shows whether the counter start points are counted from the right edge and do not drift by one. Sweeping the delay code over several frames shows whether the output enable comes exactly at the chosen VSYNC and then stays high. Running with `white_en` both set and clear separates the white fill from the zero fill and from the pass-through data.

// File: rtl/panel_frame_tracker.sv
module panel_frame_tracker #(
  parameter int CNT_W  = 11,
  parameter int DATA_W = 24,
  parameter int VS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [CNT_W-1:0]  vbp,
  input  logic [CNT_W-1:0]  hbp,
  input  logic [1:0]        pwr_dly,
  input  logic              test_mode,
  input  logic              white_en,
  input  logic [DATA_W-1:0] pix_in,
  output logic [CNT_W-1:0]  line_cnt,
  output logic [CNT_W-1:0]  pix_cnt,
  output logic              line_vis,
  output logic              pix_vis,
  output logic              data_en,
  output logic              out_en,
  output logic [DATA_W-1:0] pix_out
);

  localparam logic [VS_W-1:0] VS_MAX = {VS_W{1'b1}};
  localparam logic [CNT_W-1:0] CLK_MAX = {CNT_W{1'b1}};

  logic hs_d, vs_d;
  logic hs_fall, vs_fall;
  logic [CNT_W-1:0] hs_seen, clk_seen;
  logic [VS_W-1:0]  vs_seen;
  logic [VS_W-1:0]  vs_target;

  assign hs_fall   = hs_d & ~hsync;
  assign vs_fall   = vs_d & ~vsync;
  assign vs_target = VS_W'(pwr_dly) + VS_W'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_d <= 1'b1;
      vs_d <= 1'b1;
    end else begin
      hs_d <= hsync;
      vs_d <= vsync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_seen  <= '0;
      line_vis <= 1'b0;
      line_cnt <= '0;
    end else if (vs_fall) begin
      hs_seen  <= '0;
      line_vis <= 1'b0;
      line_cnt <= '0;
    end else if (hs_fall) begin
      if (line_vis) begin
        line_cnt <= line_cnt + 1'b1;
      end else if (CNT_W'(hs_seen + 1'b1) == vbp) begin
        line_vis <= 1'b1;
        line_cnt <= '0;
      end else begin
        hs_seen <= hs_seen + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_seen <= '0;
      pix_vis  <= 1'b0;
      pix_cnt  <= '0;
    end else if (hs_fall) begin
      clk_seen <= '0;
      pix_vis  <= 1'b0;
      pix_cnt  <= '0;
    end else if (pix_vis) begin
      pix_cnt <= pix_cnt + 1'b1;
    end else if (CNT_W'(clk_seen + 1'b1) == hbp) begin
      pix_vis <= 1'b1;
      pix_cnt <= '0;
    end else if (clk_seen != CLK_MAX) begin
      clk_seen <= clk_seen + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_seen <= '0;
      out_en  <= 1'b0;
    end else begin
      if (vs_fall && vs_seen != VS_MAX)
        vs_seen <= vs_seen + 1'b1;
      if (test_mode || (vs_fall && VS_W'(vs_seen + 1'b1) >= vs_target))
        out_en <= 1'b1;
    end
  end

  assign data_en = line_vis & pix_vis;

  always_comb begin
    if (!out_en)
      pix_out = '0;
    else if (white_en && !line_vis)
      pix_out = {DATA_W{1'b1}};
    else if (data_en)
      pix_out = pix_in;
    else
      pix_out = '0;
  end

endmodule

// File: rtl/panel_frame_tracker_chk.sv
module panel_frame_tracker_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync,
  input logic             vsync,
  input logic             test_mode,
  input logic [CNT_W-1:0] line_cnt,
  input logic [CNT_W-1:0] pix_cnt,
  input logic             line_vis,
  input logic             pix_vis,
  input logic             out_en
);

  // R8
  out_en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |=> out_en);

  // R7
  test_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> out_en);

  // R2
  vs_clears_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vsync) && !vsync) |=> !line_vis);

  // R4
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pix_vis) && pix_vis) |-> pix_cnt == CNT_W'($past(pix_cnt) + 1'b1));

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync == $past(hsync) && vsync == $past(vsync)) |=> $stable(line_cnt));

endmodule

bind panel_frame_tracker panel_frame_tracker_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
  .test_mode(test_mode), .line_cnt(line_cnt), .pix_cnt(pix_cnt),
  .line_vis(line_vis), .pix_vis(pix_vis), .out_en(out_en)
);

// File: tb/panel_frame_tracker_tb_top.sv
module panel_frame_tracker_tb_top;
  localparam int CW = 11;
  localparam int DW = 8;
  localparam int LL = 12;
  localparam int NL = 6;
  localparam int NF = 6;

  logic clk = 1'b0, rst_n = 1'b0, hsync = 1'b1, vsync = 1'b1;
  logic [CW-1:0] vbp = 1, hbp = 1;
  logic [1:0] pwr_dly = 0;
  logic test_mode = 0, white_en = 0;
  logic [DW-1:0] pix_in = 0;
  logic [CW-1:0] line_cnt, pix_cnt;
  logic line_vis, pix_vis, data_en, out_en;
  logic [DW-1:0] pix_out;
  int errors = 0, checks = 0;
  int cur_frame = 0;

  always #2 clk = ~clk;

  panel_frame_tracker #(.CNT_W(CW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .vbp(vbp), .hbp(hbp),
    .pwr_dly(pwr_dly), .test_mode(test_mode), .white_en(white_en), .pix_in(pix_in),
    .line_cnt(line_cnt), .pix_cnt(pix_cnt), .line_vis(line_vis), .pix_vis(pix_vis),
    .data_en(data_en), .out_en(out_en), .pix_out(pix_out));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_oe(input int f);
    return test_mode || (f >= int'(pwr_dly) + 2);
  endfunction

  task automatic do_line(input int n);
    bit lv, pv, oe;
    logic [DW-1:0] po;
    int lc;
    @(negedge clk) hsync = 1'b0;
    @(negedge clk) hsync = 1'b1;
    lv = (n >= int'(vbp));
    lc = lv ? n - int'(vbp) : 0;
    oe = exp_oe(cur_frame);
    for (int j = 0; j < LL; j++) begin
      if (j > 0) @(negedge clk);
      pix_in = DW'(cur_frame * 37 + n * 11 + j * 5 + 1);
      #1;
      pv = (j >= int'(hbp));
      // R3
      chk(line_vis == lv && line_cnt == CW'(lc), "R3 line", line_cnt, lc);
      // R4
      chk(pix_vis == pv && (!pv || pix_cnt == CW'(j - int'(hbp))), "R4 pixel", pix_cnt, pv ? j - int'(hbp) : 0);
      // R5
      chk(data_en == (lv && pv), "R5 data_en", data_en, lv && pv);
      // R9
      if (!oe) po = '0;
      else if (white_en && !lv) po = '1;
      else if (lv && pv) po = pix_in;
      else po = '0;
      chk(pix_out == po, "R9 pix_out", pix_out, po);
    end
  endtask

  task automatic do_frame();
    @(negedge clk) vsync = 1'b0;
    @(negedge clk) vsync = 1'b1;
    cur_frame++;
    #1;
    // R2
    chk(!line_vis && line_cnt == 0, "R2 vsync clear", line_cnt, 0);
    // R6 R7 R8
    chk(out_en == exp_oe(cur_frame), test_mode ? "R7 out_en" : "R6 R8 out_en", out_en, exp_oe(cur_frame));
    for (int n = 1; n <= NL; n++) do_line(n);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hv[3] = '{1, 2, 5};
    int vv[2] = '{1, 3};
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 2; b++)
        for (int d = 0; d < 4; d++)
          for (int t = 0; t < 2; t++) begin
            @(negedge clk);
            rst_n = 1'b0; hsync = 1'b1; vsync = 1'b1;
            hbp = CW'(hv[a]); vbp = CW'(vv[b]); pwr_dly = 2'(d);
            test_mode = t[0]; white_en = d[0] ^ b[0];
            cur_frame = 0;
            @(negedge clk); @(negedge clk);
            #1;
            // R1
            chk(!line_vis && !pix_vis && !data_en && !out_en && line_cnt == 0 && pix_cnt == 0 && pix_out == 0,
                "R1 reset", {line_vis, pix_vis, out_en}, 0);
            rst_n = 1'b1;
            @(negedge clk); #1;
            // R7: test mode enables at first edge, else still off
            chk(out_en == test_mode, test_mode ? "R7 first edge" : "R6 before vsync", out_en, test_mode);
            for (int f = 0; f < NF; f++) do_frame();
          end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule